// File: doc/BRIEF.md
# Disk Host-Port Task Register File

This block is the device end of a parallel disk host port. The host selects one of two register groups with two select lines and a 3-bit offset. It reads or writes 8-bit registers through single-cycle strobes, and it moves 16-bit words through a data port. The block keeps the parameter registers that the host loads before a command. It builds the status byte, keeps a pending interrupt, and decodes one command: a PIO sector write.

During a sector write the block asks the host for data by raising DRQ. It collects one sector of words into a local buffer. It then goes busy and hands the sector to a backend through a request/acknowledge pair. The backend reads the sector out of the buffer by word index. Each acknowledged sector lowers the remaining count and posts an interrupt. The whole DRQ-then-BSY cycle then repeats until the count runs out. Any other command code is rejected with an abort error.

Top module: `ata_taskfile`

## Requirements
- R1: With `cs_cmd`=1 and `cs_ctl`=0, read offsets are 1 error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head and 7 status; offsets 2 to 6 are writable and offset 7 takes a command. With `cs_ctl`=1 and `cs_cmd`=0, offset 6 reads alternate status and takes device-control writes. After reset, sector count and sector number read 1 and the other parameter registers read 0.
- R2: The status byte has BSY in bit 7, DRDY in bit 6, DRQ in bit 3 and ERR in bit 0, and bits 5, 4, 2 and 1 read 0. DRDY reads 1 from reset on, and alternate status always equals status.
- R3: A status read clears the pending interrupt, and an alternate-status read leaves it as it was. `irq` equals the pending interrupt gated by device-control bit 1 (1 = masked).
- R4: The command code 0x30, written while BSY=0, clears ERR and the error register and sets DRQ=1 with BSY=0 on the next cycle.
- R5: While DRQ=1, each data-port write (offset 0) stores its word at the next buffer index, starting at 0. Exactly 256 writes drop DRQ and raise BSY and `sec_req`; 255 writes leave DRQ at 1.
- R6: While BSY=1, writes to any command-block offset, command included, change no register and no state.
- R7: A `sec_ack` pulse while `sec_req`=1 decrements sector count and posts an interrupt. If the count was 1, BSY and DRQ both go to 0; otherwise DRQ returns to 1 for the next sector. A starting count of 0 stands for 256 sectors.
- R8: `blk_addr` is {drive/head[3:0], cylinder high, cylinder low, sector number}, and `lba_mode` is drive/head bit 6. In LBA mode each acknowledged sector increments that 28-bit address; in CHS mode the address is left unchanged.
- R9: Any other command code, written while BSY=0, sets ERR and error register bit 2 (value 0x04), posts an interrupt and leaves DRQ at 0.
- R10: BSY and DRQ are never both 1, and `sec_req` is 1 only while BSY is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_cmd | input | 1 | Selects the command register group |
| cs_ctl | input | 1 | Selects the control register group |
| addr | input | 3 | Register offset |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 16 | Write data (registers use bits 7:0) |
| rdata | output | 16 | Read data, combinational from the offset |
| irq | output | 1 | Interrupt request to the host |
| sec_req | output | 1 | A full sector is waiting for the backend |
| sec_ack | input | 1 | Backend has committed the sector |
| buf_raddr | input | 8 | Backend word index into the sector buffer |
| buf_rdata | output | 16 | Buffer word at `buf_raddr` |
| blk_addr | output | 28 | Current block address from the parameter registers |
| lba_mode | output | 1 | Drive/head bit 6 |

## Verification
The assertions watch the invariants on every cycle. BSY and DRQ are never both set, and the backend request is only raised while busy. Bit 1 of status stays 0. An alternate-status read never drops the pending interrupt, and a status read always drops it. Writes made while busy leave the parameters frozen, and every acknowledged sector lowers the count by one. The bench's scenarios show what needs a full sequence to observe: the word order in the buffer, DRQ dropping after exactly the 256th word and not the 255th, the path through two sectors to completion, LBA stepping, and the abort error code.

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter int SECTOR_WORDS = 256,
  parameter int DW = 16,
  parameter logic [7:0] CMD_WRITE = 8'h30,
  localparam int WAW = $clog2(SECTOR_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_cmd,
  input  logic           cs_ctl,
  input  logic [2:0]     addr,
  input  logic           rd_stb,
  input  logic           wr_stb,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq,
  output logic           sec_req,
  input  logic           sec_ack,
  input  logic [WAW-1:0] buf_raddr,
  output logic [DW-1:0]  buf_rdata,
  output logic [27:0]    blk_addr,
  output logic           lba_mode
);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_COMMIT} phase_t;

  phase_t         phase;
  logic [7:0]     r_err, r_cnt, r_sec, r_cyl_lo, r_cyl_hi, r_dh;
  logic           err_bit, pend, mask_int;
  logic [WAW-1:0] wptr;
  logic [DW-1:0]  sbuf [SECTOR_WORDS];

  logic bsy, drq;
  assign bsy = (phase == S_COMMIT);
  assign drq = (phase == S_XFER);

  logic grp_cmd, grp_ctl;
  assign grp_cmd = cs_cmd & ~cs_ctl;
  assign grp_ctl = cs_ctl & ~cs_cmd;

  logic host_wr, cmd_wr, data_wr, stat_rd, alt_rd, ctl_wr, commit;
  assign host_wr = grp_cmd & wr_stb & ~bsy;
  assign cmd_wr  = host_wr & (addr == 3'd7);
  assign data_wr = host_wr & (addr == 3'd0) & drq;
  assign stat_rd = grp_cmd & rd_stb & (addr == 3'd7);
  assign alt_rd  = grp_ctl & rd_stb & (addr == 3'd6);
  assign ctl_wr  = grp_ctl & wr_stb & (addr == 3'd6);
  assign commit  = bsy & sec_ack;

  logic [7:0] status;
  assign status = {bsy, 1'b1, 2'b00, drq, 2'b00, err_bit};

  logic last_word, is_write, is_last_sec;
  assign last_word   = (wptr == WAW'(SECTOR_WORDS - 1));
  assign is_write    = (wdata[7:0] == CMD_WRITE);
  assign is_last_sec = (r_cnt == 8'd1);

  assign blk_addr = {r_dh[3:0], r_cyl_hi, r_cyl_lo, r_sec};
  assign lba_mode = r_dh[6];
  logic [27:0] blk_next;
  assign blk_next = blk_addr + 28'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      r_err    <= 8'h00;
      r_cnt    <= 8'h01;
      r_sec    <= 8'h01;
      r_cyl_lo <= 8'h00;
      r_cyl_hi <= 8'h00;
      r_dh     <= 8'h00;
      err_bit  <= 1'b0;
      pend     <= 1'b0;
      mask_int <= 1'b0;
      wptr     <= '0;
    end else begin
      if (stat_rd) pend <= 1'b0;
      if (ctl_wr) mask_int <= wdata[1];
      if (host_wr) begin
        case (addr)
          3'd2: r_cnt    <= wdata[7:0];
          3'd3: r_sec    <= wdata[7:0];
          3'd4: r_cyl_lo <= wdata[7:0];
          3'd5: r_cyl_hi <= wdata[7:0];
          3'd6: r_dh     <= wdata[7:0];
          default: ;
        endcase
      end
      if (cmd_wr) begin
        wptr <= '0;
        if (is_write) begin
          phase   <= S_XFER;
          err_bit <= 1'b0;
          r_err   <= 8'h00;
          pend    <= 1'b0;
        end else begin
          phase   <= S_IDLE;
          err_bit <= 1'b1;
          r_err   <= 8'h04;
          pend    <= 1'b1;
        end
      end else if (data_wr) begin
        wptr <= wptr + 1'b1;
        if (last_word) phase <= S_COMMIT;
      end else if (commit) begin
        r_cnt <= r_cnt - 8'd1;
        pend  <= 1'b1;
        wptr  <= '0;
        phase <= is_last_sec ? S_IDLE : S_XFER;
        if (r_dh[6]) begin
          r_dh[3:0] <= blk_next[27:24];
          r_cyl_hi  <= blk_next[23:16];
          r_cyl_lo  <= blk_next[15:8];
          r_sec     <= blk_next[7:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr) sbuf[wptr] <= wdata;
  end

  assign buf_rdata = sbuf[buf_raddr];
  assign sec_req   = bsy;
  assign irq       = pend & ~mask_int;

  always_comb begin
    rdata = '0;
    if (grp_cmd) begin
      case (addr)
        3'd1: rdata[7:0] = r_err;
        3'd2: rdata[7:0] = r_cnt;
        3'd3: rdata[7:0] = r_sec;
        3'd4: rdata[7:0] = r_cyl_lo;
        3'd5: rdata[7:0] = r_cyl_hi;
        3'd6: rdata[7:0] = r_dh;
        3'd7: rdata[7:0] = status;
        default: rdata = '0;
      endcase
    end else if (grp_ctl && addr == 3'd6) begin
      rdata[7:0] = status;
    end
  end

  // R10
  busy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));

  // R10
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req |-> status[7]);

  // R2
  bit1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1]);

  // R3
  alt_keeps_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_rd && pend) |=> pend);

  // R3
  stat_clears_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wr_stb && !sec_ack) |=> !pend);

  // R6
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_cmd && wr_stb && status[7] && !sec_ack) |=>
      ($stable(blk_addr) && $stable(r_cnt) && $stable(phase)));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_req && sec_ack) |=> (r_cnt == $past(r_cnt) - 8'd1) && pend);

endmodule

// File: tb/test_ata_taskfile.sv
module test_ata_taskfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_cmd = 1'b0, cs_ctl = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, sec_req;
  logic        sec_ack = 1'b0;
  logic [7:0]  buf_raddr = '0;
  logic [15:0] buf_rdata;
  logic [27:0] blk_addr;
  logic        lba_mode;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ata_taskfile i_ata_taskfile (
    .clk(clk), .rst_n(rst_n), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .irq(irq),
    .sec_req(sec_req), .sec_ack(sec_ack), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata), .blk_addr(blk_addr), .lba_mode(lba_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic ctl, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_cmd = ~ctl; cs_ctl = ctl; addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cs_cmd = 1'b0; cs_ctl = 1'b0;
  endtask

  task automatic rd_reg(input logic ctl, input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    cs_cmd = ~ctl; cs_ctl = ctl; addr = a; rd_stb = 1'b1;
    #1 v = rdata[7:0];
    @(negedge clk);
    rd_stb = 1'b0; cs_cmd = 1'b0; cs_ctl = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int s, input int i);
    return 16'((s * 16'h1357) ^ (i * 16'h0101) ^ 16'hA5C3);
  endfunction

  task automatic fill_sector(input int s, input int n);
    for (int i = 0; i < n; i++) wr_reg(1'b0, 3'd0, pat(s, i));
  endtask

  task automatic ack_sector;
    @(negedge clk); sec_ack = 1'b1;
    @(negedge clk); sec_ack = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(1'b0, 3'd7, v); chk("R2 reset status", v, 8'h40);
    rd_reg(1'b0, 3'd2, v); chk("R1 reset count", v, 8'h01);
    rd_reg(1'b0, 3'd3, v); chk("R1 reset sector", v, 8'h01);
    rd_reg(1'b0, 3'd5, v); chk("R1 reset cyl hi", v, 8'h00);
    chk("R3 reset irq", irq, 1'b0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr_reg(1'b0, 3'd6, 16'h00E5);
    wr_reg(1'b0, 3'd5, 16'h0012);
    wr_reg(1'b0, 3'd4, 16'h0034);
    wr_reg(1'b0, 3'd3, 16'h0056);
    wr_reg(1'b0, 3'd2, 16'h0002);
    rd_reg(1'b0, 3'd4, v); chk("R1 cyl lo readback", v, 8'h34);
    rd_reg(1'b0, 3'd6, v); chk("R1 drive/head readback", v, 8'hE5);
    #1;
    chk("R8 block address", blk_addr, 28'h5123456);
    chk("R8 lba flag", lba_mode, 1'b1);
  endtask

  task automatic t_write_two;
    logic [7:0] v;
    wr_reg(1'b0, 3'd7, 16'h0030);
    rd_reg(1'b0, 3'd7, v); chk("R4 drq after command", v, 8'h48);
    fill_sector(0, 255);
    rd_reg(1'b1, 3'd6, v); chk("R5 drq held after 255 words", v, 8'h48);
    fill_sector_tail(0);
    rd_reg(1'b1, 3'd6, v); chk("R5 busy after 256 words", v, 8'hC0);
    chk("R10 request raised", sec_req, 1'b1);
    buf_raddr = 8'd0;   #1 chk("R5 buffer word 0", buf_rdata, pat(0, 0));
    buf_raddr = 8'd200; #1 chk("R5 buffer word 200", buf_rdata, pat(0, 200));
    buf_raddr = 8'd255; #1 chk("R5 buffer word 255", buf_rdata, pat(0, 255));
    wr_reg(1'b0, 3'd4, 16'h00AA);
    wr_reg(1'b0, 3'd7, 16'h00EC);
    rd_reg(1'b1, 3'd6, v); chk("R6 command ignored while busy", v, 8'hC0);
    ack_sector;
    rd_reg(1'b0, 3'd2, v); chk("R7 count decremented", v, 8'h01);
    rd_reg(1'b0, 3'd4, v); chk("R6 cyl lo unchanged while busy", v, 8'h34);
    #1 chk("R8 lba stepped", blk_addr, 28'h5123457);
    chk("R7 irq after sector", irq, 1'b1);
    rd_reg(1'b1, 3'd6, v); chk("R7 next sector drq", v, 8'h48);
    #1 chk("R3 alt read keeps irq", irq, 1'b1);
    rd_reg(1'b0, 3'd7, v);
    #1 chk("R3 status read clears irq", irq, 1'b0);
    fill_sector(1, 256);
    buf_raddr = 8'd7; #1 chk("R5 second sector data", buf_rdata, pat(1, 7));
    ack_sector;
    rd_reg(1'b1, 3'd6, v); chk("R7 done status", v, 8'h40);
    chk("R10 request dropped", sec_req, 1'b0);
    chk("R7 irq at completion", irq, 1'b1);
    rd_reg(1'b0, 3'd2, v); chk("R7 count zero", v, 8'h00);
    rd_reg(1'b0, 3'd7, v);
  endtask

  task automatic fill_sector_tail(input int s);
    wr_reg(1'b0, 3'd0, pat(s, 255));
  endtask

  task automatic t_chs_and_count0;
    logic [7:0] v;
    wr_reg(1'b0, 3'd6, 16'h00A3);
    wr_reg(1'b0, 3'd3, 16'h0009);
    wr_reg(1'b0, 3'd2, 16'h0000);
    wr_reg(1'b0, 3'd7, 16'h0030);
    fill_sector(2, 256);
    ack_sector;
    rd_reg(1'b0, 3'd2, v); chk("R7 count zero means 256", v, 8'hFF);
    rd_reg(1'b1, 3'd6, v); chk("R7 more sectors pending", v, 8'h48);
    #1 chk("R8 chs address fixed", blk_addr, 28'h3123409);
    chk("R8 chs flag", lba_mode, 1'b0);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    wr_reg(1'b0, 3'd7, 16'h00EC);
    rd_reg(1'b1, 3'd6, v); chk("R9 abort status", v, 8'h41);
    rd_reg(1'b0, 3'd1, v); chk("R9 abort error code", v, 8'h04);
    chk("R9 abort irq", irq, 1'b1);
    wr_reg(1'b1, 3'd6, 16'h0002);
    #1 chk("R3 irq masked", irq, 1'b0);
    wr_reg(1'b1, 3'd6, 16'h0000);
    #1 chk("R3 irq unmasked", irq, 1'b1);
    wr_reg(1'b0, 3'd7, 16'h0030);
    rd_reg(1'b0, 3'd7, v); chk("R4 error cleared by write command", v, 8'h48);
    rd_reg(1'b0, 3'd1, v); chk("R4 error register cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_write_two;
    t_chs_and_count0;
    t_abort;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule